// File: doc/BRIEF.md
# Out-of-Window Light Reading Alarm

This block watches the stream of finished 16-bit light readings from a conversion core and decides when the light level has stayed outside a programmed band for long enough to warrant an alarm. The band is set by two 8-bit bytes. Each byte forms the upper half of a 16-bit bound, and the lower half of that bound is always zero. A 2-bit run-length code sets how many consecutive out-of-band readings must arrive before the alarm fires. The code choices are 1, 4, 8 or 16 readings. With this filter a brief flash or a short dip can be ignored.

When the alarm fires, a status bit goes to 1 and a pull-down enable for an open-drain alarm line is asserted. Both stay asserted until the host sends an explicit clear pulse. The clear pulse also restarts the run count. While the conversion core is switched off, the run count is held at zero and any alarm already raised stays as it is.

Top module: `win_irq_top`

## Requirements
- R1: After reset, `irq_flag` is 0 and `irq_pull_low` is 0, and the run count is zero.
- R2: A reading on `rd_data` counts as out of band only when it is strictly greater than `{thr_hi, 8'h00}` or strictly less than `{thr_lo, 8'h00}`. A reading equal to either bound is in band.
- R3: With `persist_code` equal to 0, 1, 2 or 3, the alarm fires on the 1st, 4th, 8th or 16th consecutive out-of-band reading respectively. `irq_flag` reads 1 from the clock edge after that reading's strobe.
- R4: An in-band reading presented with `rd_valid` resets the run count to zero.
- R5: Once set, `irq_flag` and `irq_pull_low` both stay at 1 until a clear pulse, whatever readings arrive afterwards.
- R6: A cycle with `clr_cmd` high sets `irq_flag` to 0 and resets the run count from the next edge on. If a trigger falls in the same cycle as a clear, the clear wins.
- R7: While `core_en` is 0, strobed readings are ignored, the run count is held at zero, and an existing alarm is kept.
- R8: The run count changes only in cycles with `rd_valid` high. Values on `rd_data` in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_en | input | 1 | Conversion core enabled |
| rd_valid | input | 1 | One-cycle strobe: a finished reading is on `rd_data` |
| rd_data | input | 16 | Finished light reading |
| thr_hi | input | 8 | Upper bound, bits 15:8 |
| thr_lo | input | 8 | Lower bound, bits 15:8 |
| persist_code | input | 2 | Run-length code: 0→1, 1→4, 2→8, 3→16 readings |
| clr_cmd | input | 1 | One-cycle alarm clear |
| irq_flag | output | 1 | Alarm status bit |
| irq_pull_low | output | 1 | Pull-down enable for the active-low open-drain alarm line |

## Verification
The hardest cases to reach are the edges of the run count. One is a run that breaks one reading short of the 16-reading threshold and then has to be built again from zero. Another is a clear that arrives in the same cycle as the reading that would complete a run. Directed sequences build each run to exactly one short of the threshold. They then insert either an in-band reading, a disabled-core cycle or a coincident clear. The random phase draws readings from narrow bands around each bound, including the exact bound values. This gives long out-of-band runs that are interleaved with clears and disable cycles.

// File: rtl/win_irq_pkg.sv
package win_irq_pkg;

  // Number of consecutive out-of-band readings demanded by a run-length code:
  // code 0 -> 1, code k>0 -> 2^(k+1).
  function automatic int run_need(input int code);
    if (code == 0) return 1;
    return 1 << (code + 1);
  endfunction

  // Longest run any code can demand for a given code width.
  function automatic int run_max(input int code_w);
    return run_need((1 << code_w) - 1);
  endfunction

endpackage

// File: rtl/win_cmp.sv
module win_cmp #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 8
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [THR_W-1:0]  bound_hi,
  input  logic [THR_W-1:0]  bound_lo,
  output logic              above,
  output logic              below
);
  localparam int PAD_W = DATA_W - THR_W;

  logic [DATA_W-1:0] hi_full;
  logic [DATA_W-1:0] lo_full;

  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_full = {bound_hi, {PAD_W{1'b0}}};
      assign lo_full = {bound_lo, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign hi_full = bound_hi[THR_W-1 -: DATA_W];
      assign lo_full = bound_lo[THR_W-1 -: DATA_W];
    end
  endgenerate

  always_comb begin
    above = (sample > hi_full);
    below = (sample < lo_full);
  end
endmodule

// File: rtl/run_counter.sv
module run_counter #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hold_zero,
  input  logic              step,
  input  logic              outside,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  import win_irq_pkg::*;

  localparam int MAX_RUN = run_max(CODE_W);
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W:0]   cnt_plus;
  logic [CNT_W:0]   need;

  always_comb begin
    need = '0;
    for (int k = 0; k < (1 << CODE_W); k++) begin
      if (code == CODE_W'(k)) need = (CNT_W+1)'(run_need(k));
    end
  end

  always_comb begin
    cnt_plus = {1'b0, cnt_q} + 1'b1;
    hit      = step && outside && (cnt_plus >= need);
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr || hold_zero) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (step) begin
      cnt_en = 1'b1;
      if (!outside) begin
        cnt_d = '0;
      end else if (cnt_plus > (CNT_W+1)'(MAX_RUN)) begin
        cnt_d = CNT_W'(MAX_RUN);
      end else begin
        cnt_d = cnt_plus[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic upd;

  always_comb begin
    upd    = set || clr;
    flag_d = clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (upd) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/win_irq_top.sv
module win_irq_top #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 8,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_en,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [THR_W-1:0]  thr_hi,
  input  logic [THR_W-1:0]  thr_lo,
  input  logic [CODE_W-1:0] persist_code,
  input  logic              clr_cmd,
  output logic              irq_flag,
  output logic              irq_pull_low
);
  logic above;
  logic below;
  logic outside;
  logic step;
  logic hit;
  logic flag;

  win_cmp #(.DATA_W(DATA_W), .THR_W(THR_W)) u_cmp (
    .sample   (rd_data),
    .bound_hi (thr_hi),
    .bound_lo (thr_lo),
    .above    (above),
    .below    (below)
  );

  always_comb begin
    outside = above || below;
    step    = rd_valid && core_en;
  end

  run_counter #(.CODE_W(CODE_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_cmd),
    .hold_zero (!core_en),
    .step      (step),
    .outside   (outside),
    .code      (persist_code),
    .hit       (hit)
  );

  irq_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit),
    .clr   (clr_cmd),
    .flag  (flag)
  );

  assign irq_flag     = flag;
  assign irq_pull_low = flag;
endmodule

// File: rtl/win_irq_chk.sv
module win_irq_chk #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 8,
  parameter int CODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [THR_W-1:0]  thr_hi,
  input logic [THR_W-1:0]  thr_lo,
  input logic [CODE_W-1:0] persist_code,
  input logic              clr_cmd,
  input logic              irq_flag,
  input logic              irq_pull_low
);
  localparam int PAD_W = DATA_W - THR_W;

  logic [DATA_W-1:0] hi_b;
  logic [DATA_W-1:0] lo_b;
  logic              in_band;

  assign hi_b    = {thr_hi, {PAD_W{1'b0}}};
  assign lo_b    = {thr_lo, {PAD_W{1'b0}}};
  assign in_band = (rd_data <= hi_b) && (rd_data >= lo_b);

  // R5: the alarm stays raised without a clear
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_cmd) |=> irq_flag);

  // R6: a clear always drops the alarm, even against a trigger
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !irq_flag);

  // R7: a disabled core never raises the alarm
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_en && !irq_flag) |=> !irq_flag);

  // R8: no strobe, no new alarm
  assert_strobe_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !irq_flag) |=> !irq_flag);

  // R2 / R4: an in-band reading never raises the alarm
  assert_in_band_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && in_band && !irq_flag) |=> !irq_flag);

  // R5: pull-down enable tracks the status bit
  assert_line_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_low == irq_flag);
endmodule

bind win_irq_top win_irq_chk #(.DATA_W(DATA_W), .THR_W(THR_W), .CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_en      (core_en),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .thr_hi       (thr_hi),
  .thr_lo       (thr_lo),
  .persist_code (persist_code),
  .clr_cmd      (clr_cmd),
  .irq_flag     (irq_flag),
  .irq_pull_low (irq_pull_low)
);

// File: tb/tb_win_irq_top.sv
`timescale 1ns/1ps
module tb_win_irq_top;
  logic        clk;
  logic        rst_n;
  logic        core_en;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [7:0]  thr_hi;
  logic [7:0]  thr_lo;
  logic [1:0]  persist_code;
  logic        clr_cmd;
  logic        irq_flag;
  logic        irq_pull_low;

  int checks = 0;
  int errors = 0;
  int m_cnt  = 0;
  bit m_flag = 0;

  win_irq_top dut (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .persist_code(persist_code), .clr_cmd(clr_cmd),
    .irq_flag(irq_flag), .irq_pull_low(irq_pull_low)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int need_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic bit out_of_band(input logic [15:0] d, input logic [7:0] h, input logic [7:0] l);
    return (d > {h, 8'h00}) || (d < {l, 8'h00});
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_out(input string tag);
    check(irq_flag, m_flag, tag);
    check(irq_pull_low, m_flag, tag);
  endtask

  // One cycle: inputs driven now (at a falling edge), model updated at the rising edge.
  task automatic cyc(input bit en, input bit v, input logic [15:0] d, input bit c);
    core_en = en; rd_valid = v; rd_data = d; clr_cmd = c;
    @(posedge clk);
    if (c) begin
      m_cnt = 0; m_flag = 0;
    end else if (!en) begin
      m_cnt = 0;
    end else if (v) begin
      if (out_of_band(d, thr_hi, thr_lo)) begin
        if (m_cnt + 1 >= need_of(persist_code)) m_flag = 1;
        m_cnt = (m_cnt + 1 > 16) ? 16 : m_cnt + 1;
      end else begin
        m_cnt = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic do_clear();
    cyc(1, 0, 16'h0, 1);
    check_out("R6 clear");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; core_en = 0; rd_valid = 0; rd_data = 0; clr_cmd = 0;
    thr_hi = 8'h80; thr_lo = 8'h20; persist_code = 2'd0;
    repeat (3) @(negedge clk);
    check(irq_flag, 1'b0, "R1 reset flag");
    check(irq_pull_low, 1'b0, "R1 reset line");
    rst_n = 1;
    @(negedge clk);
    check_out("R1 after release");

    // R2: exact bounds are in band; one above the upper bound fires with code 0
    cyc(1, 1, 16'h8000, 0); check_out("R2 equal upper bound");
    cyc(1, 1, 16'h2000, 0); check_out("R2 equal lower bound");
    cyc(1, 1, 16'h8001, 0); check_out("R2 just above");
    check(irq_flag, 1'b1, "R2 just above fires");
    cyc(1, 1, 16'h5000, 0); check_out("R5 sticky after in-band");
    do_clear();
    cyc(1, 1, 16'h1FFF, 0); check(irq_flag, 1'b1, "R2 just below fires");
    do_clear();

    // R8: readings without strobe do nothing
    cyc(1, 0, 16'hFFFF, 0); check(irq_flag, 1'b0, "R8 no strobe");

    // R3 / R4: code 1 needs 4; break at 3 with an in-band reading
    persist_code = 2'd1;
    for (int i = 0; i < 3; i++) cyc(1, 1, 16'hF000, 0);
    check(irq_flag, 1'b0, "R3 three of four");
    cyc(1, 1, 16'h4000, 0);
    for (int i = 0; i < 3; i++) cyc(1, 1, 16'h0010, 0);
    check(irq_flag, 1'b0, "R4 run restarted");
    cyc(1, 1, 16'h0010, 0); check(irq_flag, 1'b1, "R3 fourth fires");
    do_clear();

    // R3: code 2 needs 8, code 3 needs 16
    persist_code = 2'd2;
    for (int i = 0; i < 7; i++) cyc(1, 1, 16'hFFFF, 0);
    check(irq_flag, 1'b0, "R3 seven of eight");
    cyc(1, 1, 16'hFFFF, 0); check(irq_flag, 1'b1, "R3 eighth fires");
    do_clear();
    persist_code = 2'd3;
    for (int i = 0; i < 15; i++) cyc(1, 1, 16'hFFFF, 0);
    check(irq_flag, 1'b0, "R3 fifteen of sixteen");
    cyc(1, 1, 16'hFFFF, 0); check(irq_flag, 1'b1, "R3 sixteenth fires");
    do_clear();

    // R6: clear coincident with completing reading wins, and resets the run
    for (int i = 0; i < 15; i++) cyc(1, 1, 16'hFFFF, 0);
    cyc(1, 1, 16'hFFFF, 1); check(irq_flag, 1'b0, "R6 clear beats trigger");
    cyc(1, 1, 16'hFFFF, 0); check(irq_flag, 1'b0, "R6 run reset by clear");

    // R7: disable holds run at zero, ignores strobes
    do_clear();
    for (int i = 0; i < 15; i++) cyc(1, 1, 16'hFFFF, 0);
    cyc(0, 1, 16'hFFFF, 0); check(irq_flag, 1'b0, "R7 strobe ignored");
    cyc(1, 1, 16'hFFFF, 0); check(irq_flag, 1'b0, "R7 run zeroed");
    persist_code = 2'd0;
    cyc(1, 1, 16'hFFFF, 0); check(irq_flag, 1'b1, "R7 setup fire");
    cyc(0, 1, 16'h4000, 0); check(irq_flag, 1'b1, "R7 alarm kept while disabled");
    do_clear();

    // Random phase around the bounds
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      int sel;
      if (i % 250 == 0) begin
        persist_code = 2'($urandom_range(0, 3));
        thr_hi = 8'($urandom_range(8'h60, 8'hFE));
        thr_lo = 8'($urandom_range(8'h01, 8'h50));
      end
      sel = $urandom_range(0, 5);
      case (sel)
        0: d = {thr_hi, 8'h00};
        1: d = {thr_lo, 8'h00};
        2: d = {thr_hi, 8'h00} + 16'($urandom_range(1, 300));
        3: d = {thr_lo, 8'h00} - 16'($urandom_range(1, 200));
        4: d = 16'($urandom);
        default: d = {thr_lo, 8'h00} + 16'($urandom_range(0, 255));
      endcase
      cyc(($urandom_range(0, 19) != 0), ($urandom_range(0, 2) != 0), d,
          ($urandom_range(0, 39) == 0));
      check_out("R5 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule